// File: doc/BRIEF.md
# Glitch-Free Master Clock Selector with Prescaler and Crystal Monitor

This block produces the master clock of a small chip from one of four oscillators: a fast internal RC, an external crystal, an external user clock and a slow internal RC. Software asks for a new source by a register write. The block defers the change until that oscillator says it is ready. It then moves the output across with a break-before-make handshake, so the master clock never carries a shortened high or low phase. The selected clock then passes through a power-of-two prescaler. After that come independent gates for the core, the memory and each peripheral.

All register writes are accepted in the fast internal RC domain, which always runs. A missing-edge counter clocked by the slow RC watches the crystal. If the crystal stays quiet while monitoring is enabled, hardware drops it. The block then returns to the fast RC divided by 8, which is also the state it starts in after reset, and raises a sticky interrupt that software acknowledges.

Top module: `mclk_switch`

## Requirements
- R1: After reset the selector reports source code 0 (fast internal RC), the prescaler divides by 8, `sw_busy` and `css_irq` are low and every gated clock output is enabled.
- R2: Source codes are 0 fast internal RC, 1 crystal, 2 external clock, 3 slow internal RC. When a switch completes, `act_src` shows the new code and `mclk` runs at the new source's rate.
- R3: A switch to a source whose ready bit (`src_rdy` bit index equals its code) is low is held pending. `sw_busy` stays high, `act_src` keeps the old code and the old clock keeps running until the ready bit rises.
- R4: At most one source leg is enabled at any time. No `mclk` high or low phase is shorter than the shorter half period of the two clocks involved in a switch.
- R5: With `css_en` high, a crystal that shows no edge for 8 slow-RC cycles while selected or being selected forces source 0 with divide code 3 and sets `css_irq`.
- R6: With `css_en` low, a stopped crystal causes neither fallback nor interrupt. `css_irq` is set only when monitoring is enabled and clears on `irq_ack`.
- R7: Divide code d (0 to 7) on `div_sel` makes `mclk` give one high phase per 2^d selected-source cycles.
- R8: A new divide code takes effect only at a divided-clock period boundary.
- R9: `gate_sel` bit i set passes `mclk` to `gclk[i]`; bit i clear holds `gclk[i]` low (bit 0 core, bit 1 memory, higher bits peripherals).
- R10: A write selecting the source that is already active starts no switch; `sw_busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_hirc | input | 1 | Fast internal RC clock; register domain |
| clk_xtal | input | 1 | External crystal clock |
| clk_ext | input | 1 | External user clock |
| clk_lirc | input | 1 | Slow internal RC clock; monitor time base |
| src_rdy | input | 4 | Ready flag per source, indexed by source code |
| src_we | input | 1 | Write strobe for source select |
| src_sel | input | 2 | Requested source code |
| div_we | input | 1 | Write strobe for prescaler code |
| div_sel | input | DIVW | Prescaler code, divide by 2^code |
| gate_we | input | 1 | Write strobe for clock gate bits |
| gate_sel | input | NGATE | Clock gate enable bits |
| css_en | input | 1 | Crystal failure monitoring enable |
| irq_ack | input | 1 | Clears the failure interrupt |
| mclk | output | 1 | Divided master clock |
| gclk | output | NGATE | Individually gated copies of mclk |
| act_src | output | 2 | Code of the source currently driving mclk |
| sw_busy | output | 1 | A source change is pending or in progress |
| css_irq | output | 1 | Sticky crystal failure interrupt |

## Verification
Some properties are checked on every cycle by the assertions. Two source legs are never enabled together. A leg is only raised after every leg has been seen off. A pending switch only proceeds once the target is ready. A divide code is only loaded at a period boundary. A fallback always leaves the fast RC selected with divide code 3 and the interrupt set. Other behaviour needs the bench scenarios. They measure real clock rates per source and per divide code, the minimum high and low widths across live switches, the gate pattern on each output, and the fallback with monitoring on and off.

// File: rtl/mcs_pkg.sv
`timescale 1ns/1ps
package mcs_pkg;
  typedef enum logic [1:0] {
    SRC_HIRC = 2'd0,
    SRC_XTAL = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_LIRC = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DROP  = 2'd2,
    ST_RAISE = 2'd3
  } sw_st_e;

  localparam int NSRC     = 4;
  localparam int DIV_SAFE = 3;
endpackage

// File: rtl/mcs_sync.sv
`timescale 1ns/1ps
module mcs_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/mcs_leg.sv
`timescale 1ns/1ps
module mcs_leg #(
  parameter logic RST_ON = 1'b0
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic kill,
  input  logic req,
  output logic on_q,
  output logic clk_out
);
  logic arst_n;
  logic lrst_n;
  logic req_s;

  assign arst_n = rst_n & ~kill;

  mcs_sync #(.W(1), .RST_VAL(1'b0)) u_rst (
    .clk(clk_src), .rst_n(arst_n), .d(1'b1), .q(lrst_n)
  );

  mcs_sync #(.W(1), .RST_VAL(RST_ON)) u_req (
    .clk(clk_src), .rst_n(lrst_n), .d(req), .q(req_s)
  );

  // enable changes only while the source is low
  always_ff @(negedge clk_src or negedge lrst_n) begin
    if (!lrst_n) on_q <= RST_ON;
    else         on_q <= req_s;
  end

  assign clk_out = clk_src & on_q;
endmodule

// File: rtl/mcs_fail_det.sv
`timescale 1ns/1ps
module mcs_fail_det #(
  parameter int FAIL_CYC = 8
) (
  input  logic clk_xtal,
  input  logic clk_lirc,
  input  logic rst_n,
  output logic fail_o
);
  localparam int CW = $clog2(FAIL_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(FAIL_CYC);

  logic          rst_x, rst_l;
  logic          tgl_q, tgl_s, prev_q;
  logic          edge_w;
  logic [CW-1:0] cnt_q, cnt_d;

  mcs_sync #(.W(1), .RST_VAL(1'b0)) u_rx (
    .clk(clk_xtal), .rst_n(rst_n), .d(1'b1), .q(rst_x)
  );
  mcs_sync #(.W(1), .RST_VAL(1'b0)) u_rl (
    .clk(clk_lirc), .rst_n(rst_n), .d(1'b1), .q(rst_l)
  );

  always_ff @(posedge clk_xtal or negedge rst_x) begin
    if (!rst_x) tgl_q <= 1'b0;
    else        tgl_q <= ~tgl_q;
  end

  mcs_sync #(.W(1), .RST_VAL(1'b0)) u_ts (
    .clk(clk_lirc), .rst_n(rst_l), .d(tgl_q), .q(tgl_s)
  );

  assign edge_w = tgl_s ^ prev_q;

  always_comb begin
    cnt_d = cnt_q;
    if (edge_w)            cnt_d = '0;
    else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_lirc or negedge rst_l) begin
    if (!rst_l) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= tgl_s;
      cnt_q  <= cnt_d;
    end
  end

  assign fail_o = (cnt_q == LIM);

  p_quiet_window_r5: assert property (@(posedge clk_lirc) disable iff (!rst_l)
    $rose(fail_o) |-> !$past(edge_w))
    else $error("failure declared right after a crystal edge");
endmodule

// File: rtl/mcs_prescale.sv
`timescale 1ns/1ps
module mcs_prescale #(
  parameter int DIVW = 3,
  parameter int DIV_RST = 3
) (
  input  logic            clk_in,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div_code,
  output logic            clk_out
);
  localparam int CNTW = (1 << DIVW) - 1;
  localparam logic [CNTW-1:0] LIM_RST = CNTW'((1 << DIV_RST) - 1);

  logic            rst_m;
  logic [DIVW-1:0] code_s;
  logic [CNTW:0]   one_sh;
  logic [CNTW-1:0] lim_d, lim_q, lim_n;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            en_q;
  logic            wrap;

  mcs_sync #(.W(1), .RST_VAL(1'b0)) u_rst (
    .clk(clk_in), .rst_n(rst_n), .d(1'b1), .q(rst_m)
  );
  mcs_sync #(.W(DIVW), .RST_VAL(DIVW'(DIV_RST))) u_code (
    .clk(clk_in), .rst_n(rst_m), .d(div_code), .q(code_s)
  );

  always_comb begin
    one_sh = {{CNTW{1'b0}}, 1'b1} << code_s;
    lim_d  = CNTW'(one_sh - 1'b1);
    wrap   = (cnt_q == lim_q);
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    lim_n  = wrap ? lim_d : lim_q;
  end

  always_ff @(posedge clk_in or negedge rst_m) begin
    if (!rst_m) begin
      cnt_q <= '0;
      lim_q <= LIM_RST;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_n;
    end
  end

  always_ff @(negedge clk_in or negedge rst_m) begin
    if (!rst_m) en_q <= 1'b0;
    else        en_q <= (cnt_q == '0);
  end

  assign clk_out = clk_in & en_q;

  p_div_boundary_r8: assert property (@(posedge clk_in) disable iff (!rst_m)
    (lim_q != $past(lim_q)) |-> (cnt_q == '0))
    else $error("divide limit changed mid period");
endmodule

// File: rtl/mcs_gate.sv
`timescale 1ns/1ps
module mcs_gate #(
  parameter int NG = 6
) (
  input  logic          mclk,
  input  logic          rst_n,
  input  logic [NG-1:0] en_bits,
  output logic [NG-1:0] gclk
);
  logic          rst_g;
  logic [NG-1:0] en_s, en_q;

  mcs_sync #(.W(1), .RST_VAL(1'b0)) u_rst (
    .clk(mclk), .rst_n(rst_n), .d(1'b1), .q(rst_g)
  );
  mcs_sync #(.W(NG), .RST_VAL({NG{1'b1}})) u_en (
    .clk(mclk), .rst_n(rst_g), .d(en_bits), .q(en_s)
  );

  always_ff @(negedge mclk or negedge rst_g) begin
    if (!rst_g) en_q <= {NG{1'b1}};
    else        en_q <= en_s;
  end

  for (genvar i = 0; i < NG; i++) begin : g_cell
    assign gclk[i] = mclk & en_q[i];
  end
endmodule

// File: rtl/mcs_ctrl.sv
`timescale 1ns/1ps
module mcs_ctrl
  import mcs_pkg::*;
#(
  parameter int DIVW = 3,
  parameter int NG   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_we,
  input  src_e            src_in,
  input  logic            div_we,
  input  logic [DIVW-1:0] div_in,
  input  logic            gate_we,
  input  logic [NG-1:0]   gate_in,
  input  logic            css_en,
  input  logic            irq_ack,
  input  logic [NSRC-1:0] rdy_s,
  input  logic [NSRC-1:0] act_s,
  input  logic            fail_s,
  output logic [NSRC-1:0] req,
  output logic            kill_xtal,
  output logic [DIVW-1:0] div_q,
  output logic [NG-1:0]   gate_q,
  output src_e            cur_q,
  output logic            busy,
  output logic            irq_q
);
  localparam logic [DIVW-1:0] DSAFE = DIVW'(DIV_SAFE);

  sw_st_e          st_q, st_d;
  src_e            tgt_q, tgt_d, cur_d;
  logic [DIVW-1:0] div_d;
  logic [NG-1:0]   gate_d;
  logic            irq_d;
  logic            force_fb;

  assign force_fb = css_en & fail_s &
                    ((tgt_q == SRC_XTAL) |
                     ((cur_q == SRC_XTAL) & ((st_q == ST_IDLE) | (st_q == ST_WAIT))));

  always_comb begin
    st_d   = st_q;
    tgt_d  = tgt_q;
    cur_d  = cur_q;
    div_d  = div_we  ? div_in  : div_q;
    gate_d = gate_we ? gate_in : gate_q;
    irq_d  = irq_q & ~irq_ack;
    if (force_fb) begin
      tgt_d = SRC_HIRC;
      div_d = DSAFE;
      irq_d = 1'b1;
      st_d  = (cur_q == SRC_HIRC) ? ST_IDLE : ST_DROP;
    end else begin
      case (st_q)
        ST_IDLE: if (src_we && src_in != cur_q) begin
          tgt_d = src_in;
          st_d  = ST_WAIT;
        end
        ST_WAIT: begin
          if (src_we) begin
            tgt_d = src_in;
            if (src_in == cur_q) st_d = ST_IDLE;
          end else if (rdy_s[tgt_q]) begin
            st_d = ST_DROP;
          end
        end
        ST_DROP: if (act_s == '0) st_d = ST_RAISE;
        ST_RAISE: if (act_s[tgt_q]) begin
          cur_d = tgt_q;
          st_d  = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ST_DROP:  req = '0;
      ST_RAISE: req = NSRC'(1) << tgt_q;
      default:  req = NSRC'(1) << cur_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tgt_q  <= SRC_HIRC;
      cur_q  <= SRC_HIRC;
      div_q  <= DSAFE;
      gate_q <= {NG{1'b1}};
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tgt_q  <= tgt_d;
      cur_q  <= cur_d;
      div_q  <= div_d;
      gate_q <= gate_d;
      irq_q  <= irq_d;
    end
  end

  assign kill_xtal = css_en & fail_s;
  assign busy      = (st_q != ST_IDLE);

  p_defer_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DROP && $past(st_q) == ST_WAIT && !$past(force_fb))
      |-> $past(rdy_s[tgt_q]))
    else $error("switch left wait without target ready");

  p_break_before_make_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RAISE && $past(st_q) == ST_DROP) |-> ($past(act_s) == '0))
    else $error("new leg raised while a leg was still on");

  p_fallback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    force_fb |=> (tgt_q == SRC_HIRC && div_q == DSAFE && irq_q))
    else $error("fallback did not reach safe source");

  p_irq_css_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(css_en))
    else $error("interrupt raised with monitoring disabled");
endmodule

// File: rtl/mclk_switch.sv
`timescale 1ns/1ps
module mclk_switch
  import mcs_pkg::*;
#(
  parameter int DIVW     = 3,
  parameter int NGATE    = 6,
  parameter int FAIL_CYC = 8
) (
  input  logic             rst_n,
  input  logic             clk_hirc,
  input  logic             clk_xtal,
  input  logic             clk_ext,
  input  logic             clk_lirc,
  input  logic [3:0]       src_rdy,
  input  logic             src_we,
  input  logic [1:0]       src_sel,
  input  logic             div_we,
  input  logic [DIVW-1:0]  div_sel,
  input  logic             gate_we,
  input  logic [NGATE-1:0] gate_sel,
  input  logic             css_en,
  input  logic             irq_ack,
  output logic             mclk,
  output logic [NGATE-1:0] gclk,
  output logic [1:0]       act_src,
  output logic             sw_busy,
  output logic             css_irq
);
  logic            rst_h;
  logic [NSRC-1:0] src_clk, leg_on, leg_clk;
  logic [NSRC-1:0] rdy_s, act_s, req;
  logic            fail_raw, fail_s, kill_xtal;
  logic [DIVW-1:0] div_q;
  logic [NGATE-1:0] gate_q;
  src_e            cur;
  logic            mux_clk;

  assign src_clk = {clk_lirc, clk_ext, clk_xtal, clk_hirc};

  mcs_sync #(.W(1), .RST_VAL(1'b0)) u_rst_h (
    .clk(clk_hirc), .rst_n(rst_n), .d(1'b1), .q(rst_h)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_leg
    mcs_leg #(.RST_ON(g == int'(SRC_HIRC))) u_leg (
      .clk_src (src_clk[g]),
      .rst_n   (rst_n),
      .kill    ((g == int'(SRC_XTAL)) ? kill_xtal : 1'b0),
      .req     (req[g]),
      .on_q    (leg_on[g]),
      .clk_out (leg_clk[g])
    );
  end

  assign mux_clk = |leg_clk;

  mcs_sync #(.W(NSRC), .RST_VAL('0)) u_rdy (
    .clk(clk_hirc), .rst_n(rst_h), .d(src_rdy), .q(rdy_s)
  );
  mcs_sync #(.W(NSRC), .RST_VAL(NSRC'(1))) u_act (
    .clk(clk_hirc), .rst_n(rst_h), .d(leg_on), .q(act_s)
  );

  mcs_fail_det #(.FAIL_CYC(FAIL_CYC)) u_det (
    .clk_xtal(clk_xtal), .clk_lirc(clk_lirc), .rst_n(rst_n), .fail_o(fail_raw)
  );
  mcs_sync #(.W(1), .RST_VAL(1'b0)) u_fail (
    .clk(clk_hirc), .rst_n(rst_h), .d(fail_raw), .q(fail_s)
  );

  mcs_ctrl #(.DIVW(DIVW), .NG(NGATE)) u_ctrl (
    .clk       (clk_hirc),
    .rst_n     (rst_h),
    .src_we    (src_we),
    .src_in    (src_e'(src_sel)),
    .div_we    (div_we),
    .div_in    (div_sel),
    .gate_we   (gate_we),
    .gate_in   (gate_sel),
    .css_en    (css_en),
    .irq_ack   (irq_ack),
    .rdy_s     (rdy_s),
    .act_s     (act_s),
    .fail_s    (fail_s),
    .req       (req),
    .kill_xtal (kill_xtal),
    .div_q     (div_q),
    .gate_q    (gate_q),
    .cur_q     (cur),
    .busy      (sw_busy),
    .irq_q     (css_irq)
  );

  mcs_prescale #(.DIVW(DIVW), .DIV_RST(DIV_SAFE)) u_div (
    .clk_in(mux_clk), .rst_n(rst_n), .div_code(div_q), .clk_out(mclk)
  );

  mcs_gate #(.NG(NGATE)) u_gate (
    .mclk(mclk), .rst_n(rst_n), .en_bits(gate_q), .gclk(gclk)
  );

  assign act_src = cur;

  p_single_leg_r4: assert property (@(posedge clk_hirc) disable iff (!rst_n)
    $onehot0(leg_on))
    else $error("two source legs enabled together");
endmodule

// File: tb/mclk_switch_tb.sv
`timescale 1ns/1ps
module mclk_switch_tb;
  localparam int NG = 6;

  logic          rst_n = 1'b0;
  logic          clk_hirc = 1'b0, clk_xtal = 1'b0, clk_ext = 1'b0, clk_lirc = 1'b0;
  logic          xtal_run = 1'b1;
  logic [3:0]    src_rdy = 4'b1101;
  logic          src_we = 1'b0, div_we = 1'b0, gate_we = 1'b0;
  logic [1:0]    src_sel = 2'd0;
  logic [2:0]    div_sel = 3'd0;
  logic [NG-1:0] gate_sel = '1;
  logic          css_en = 1'b0, irq_ack = 1'b0;
  logic          mclk;
  logic [NG-1:0] gclk;
  logic [1:0]    act_src;
  logic          sw_busy, css_irq;

  int  checks = 0, errors = 0;
  int  mcnt = 0;
  int  gcnt [NG];
  bit  done = 1'b0;
  bit  mon = 1'b0, mon_armed = 1'b0;
  real t_last, min_hi, min_lo, dt;

  always #10 clk_hirc = ~clk_hirc;
  always #7  clk_ext  = ~clk_ext;
  always #50 clk_lirc = ~clk_lirc;
  always begin
    #15;
    if (xtal_run) clk_xtal = ~clk_xtal;
  end

  mclk_switch u_dut (
    .rst_n(rst_n), .clk_hirc(clk_hirc), .clk_xtal(clk_xtal), .clk_ext(clk_ext),
    .clk_lirc(clk_lirc), .src_rdy(src_rdy), .src_we(src_we), .src_sel(src_sel),
    .div_we(div_we), .div_sel(div_sel), .gate_we(gate_we), .gate_sel(gate_sel),
    .css_en(css_en), .irq_ack(irq_ack), .mclk(mclk), .gclk(gclk),
    .act_src(act_src), .sw_busy(sw_busy), .css_irq(css_irq)
  );

  initial for (int i = 0; i < NG; i++) gcnt[i] = 0;

  always @(posedge mclk) begin
    mcnt++;
    #1;
    for (int i = 0; i < NG; i++) if (gclk[i]) gcnt[i]++;
  end

  always @(mclk) if (mon) begin
    if (mon_armed) begin
      dt = $realtime - t_last;
      if (mclk == 1'b0) begin
        if (dt < min_hi) min_hi = dt;
      end else if (dt < min_lo) min_lo = dt;
    end
    t_last    = $realtime;
    mon_armed = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rate(input string req, input int win_ns, input int per_ns);
    int c0, n, e;
    c0 = mcnt;
    #(win_ns);
    n = mcnt - c0;
    e = win_ns / per_ns;
    chk((n >= e - 1) && (n <= e + 1), req, n, e);
  endtask

  task automatic wr_src(input logic [1:0] v);
    @(negedge clk_hirc); src_sel = v; src_we = 1'b1;
    @(negedge clk_hirc); src_we = 1'b0;
  endtask

  task automatic wr_div(input logic [2:0] v);
    @(negedge clk_hirc); div_sel = v; div_we = 1'b1;
    @(negedge clk_hirc); div_we = 1'b0;
  endtask

  task automatic wr_gate(input logic [NG-1:0] v);
    @(negedge clk_hirc); gate_sel = v; gate_we = 1'b1;
    @(negedge clk_hirc); gate_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 4000 && sw_busy; k++) @(negedge clk_hirc);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      finish_run();
    end
  end

  initial begin
    repeat (10) @(negedge clk_hirc);
    rst_n = 1'b1;
    repeat (20) @(negedge clk_hirc);

    // R1 reset state
    chk(act_src == 2'd0, "R1 act_src", act_src, 0);
    chk(!sw_busy, "R1 busy", sw_busy, 0);
    chk(!css_irq, "R1 irq", css_irq, 0);
    chk_rate("R1 hirc/8 rate", 3200, 160);
    begin
      int m0, g0;
      m0 = mcnt; g0 = gcnt[0];
      #2000;
      chk((mcnt - m0) == (gcnt[0] - g0), "R1 gate0 enabled", gcnt[0] - g0, mcnt - m0);
    end

    // R7 divide sweep on the fast RC
    for (int d = 0; d < 8; d++) begin
      wr_div(3'(d));
      #5120;
      chk_rate($sformatf("R7 div code %0d", d), 7680, 20 << d);
    end
    wr_div(3'd0);
    #6000;

    // R4 pulse monitor over live switches
    min_hi = 1.0e9; min_lo = 1.0e9; mon_armed = 1'b0; mon = 1'b1;

    // R3 deferred switch to crystal
    wr_src(2'd1);
    repeat (40) @(negedge clk_hirc);
    chk(sw_busy, "R3 busy while not ready", sw_busy, 1);
    chk(act_src == 2'd0, "R3 source held", act_src, 0);
    chk_rate("R3 old clock runs", 2000, 20);
    src_rdy = 4'b1111;
    wait_idle();
    chk(act_src == 2'd1, "R2 crystal selected", act_src, 1);
    chk_rate("R2 crystal rate", 3000, 30);

    // R10 same source write
    wr_src(2'd1);
    repeat (3) @(negedge clk_hirc);
    chk(!sw_busy, "R10 no switch", sw_busy, 0);

    wr_src(2'd2);
    wait_idle();
    chk(act_src == 2'd2, "R2 ext selected", act_src, 2);
    chk_rate("R2 ext rate", 2800, 14);
    wr_src(2'd3);
    wait_idle();
    chk(act_src == 2'd3, "R2 slow rc selected", act_src, 3);
    chk_rate("R2 slow rc rate", 4000, 100);
    wr_src(2'd0);
    wait_idle();
    chk(act_src == 2'd0, "R2 fast rc selected", act_src, 0);
    chk_rate("R2 fast rc rate", 2000, 20);
    mon = 1'b0;
    chk(min_hi >= 6.9, "R4 min high phase ns", int'(min_hi), 7);
    chk(min_lo >= 6.9, "R4 min low phase ns", int'(min_lo), 7);

    // R9 gating pattern
    wr_gate(6'b101001);
    repeat (20) @(negedge clk_hirc);
    begin
      int m0;
      int g0 [NG];
      m0 = mcnt;
      for (int i = 0; i < NG; i++) g0[i] = gcnt[i];
      #2000;
      for (int i = 0; i < NG; i++) begin
        int n, e;
        n = gcnt[i] - g0[i];
        e = ((6'b101001 >> i) & 1) != 0 ? (mcnt - m0) : 0;
        chk((n >= e - 1) && (n <= e + 1), $sformatf("R9 gclk bit %0d", i), n, e);
      end
    end
    wr_gate('1);

    // R6 crystal stop with monitoring off
    wr_src(2'd1);
    wait_idle();
    xtal_run = 1'b0;
    #3000;
    chk(!css_irq, "R6 no irq when disabled", css_irq, 0);
    chk(act_src == 2'd1, "R6 no fallback when disabled", act_src, 1);
    xtal_run = 1'b1;
    #2000;

    // R5 crystal failure with monitoring on
    css_en = 1'b1;
    #2000;
    chk(!css_irq, "R5 no irq with healthy crystal", css_irq, 0);
    xtal_run = 1'b0;
    #4000;
    chk(css_irq, "R5 irq raised", css_irq, 1);
    chk(act_src == 2'd0, "R5 fallback source", act_src, 0);
    chk(!sw_busy, "R5 fallback complete", sw_busy, 0);
    chk_rate("R5 fallback hirc/8 rate", 3200, 160);
    @(negedge clk_hirc); irq_ack = 1'b1;
    @(negedge clk_hirc); irq_ack = 1'b0;
    @(negedge clk_hirc);
    chk(!css_irq, "R6 irq cleared by ack", css_irq, 0);

    done = 1'b1;
    finish_run();
  end
endmodule